// File: doc/BRIEF.md
# I2C Double-Buffered Byte Data Path

This block is the byte-level data path of an I2C controller. Each direction has two stages: a holding register that software writes or reads, and a shift stage that moves one bit per strobe from the bit-level pin driver. Software sees three status outputs. The first shows the transmit holding register is empty. The second shows the receive holding register has data. The third, the transfer-finished flag, shows the two stages have run dry on transmit or filled up on receive.

When stretching is enabled, the transfer-finished flag asks the pin driver to hold SCL low. Nothing is lost or sent twice. The request is withdrawn after software writes the transmit holding register or reads the receive holding register. When stretching is disabled, the block keeps going. On transmit it repeats the stale byte and raises a sticky underrun flag. On receive it drops the byte that finds both stages full and raises a sticky overrun flag.

Start and stop generation, addressing and acknowledge handling are outside this block. The pin driver issues one strobe per bit slot and does not strobe while SCL is held.

Top module: `i2c_dbuf_path`

## Requirements
- R1: After reset, `btf`, `scl_hold`, `rxne`, `ovr_flag` and `udr_flag` are 0, and `txe` is 1 while `tx_mode` is 1.
- R2: In transmit (`tx_mode`=1), a write (`sw_wr`) makes `txe` 0 at that edge. If the shift stage is idle, the byte moves into it at the next edge and `txe` returns to 1. `bit_out` shows the shift stage most significant bit first, and each `bit_strobe` advances it by one bit.
- R3: In transmit, when the eighth strobe of a byte completes and the holding register is full, the next byte enters the shift stage at that same edge. `txe` goes to 1, with no gap and no `btf`.
- R4: In transmit with `stretch_en`=1, when a byte completes and the holding register is empty, `btf` is 1 after that edge and `scl_hold` is 1 one cycle later. Strobes arriving while `btf` is 1 change nothing.
- R5: In transmit, a write while `btf` is 1 clears `btf` and `txe` at that edge and clears `scl_hold` one edge later. The newly written byte is then sent.
- R6: In transmit with `stretch_en`=0, a byte completing with an empty holding register sends the last written byte again. It also sets `udr_flag`, and `btf` stays 0.
- R7: In receive (`tx_mode`=0), `bit_in` is shifted in most significant bit first, one bit per strobe. After the eighth strobe, the byte appears on `sw_rdata` and `rxne` becomes 1 if the holding register was empty.
- R8: In receive with `stretch_en`=1, a byte completing while `rxne` is 1 stays in the shift stage. `btf` is 1 after that edge and `scl_hold` is 1 one cycle later. Strobes while `btf` is 1 are ignored, including by the bit count.
- R9: In receive, a read (`sw_rd`) with the shift stage full moves that byte to `sw_rdata`, keeps `rxne` at 1 and clears `btf`. `scl_hold` drops one edge later. A read with the shift stage empty clears `rxne`.
- R10: In receive with `stretch_en`=0 and both stages full, the next eight strobes are counted but their byte is discarded. `ovr_flag` is set, and the two stored bytes are kept and read out in order.
- R11: `ovr_flag` and `udr_flag` stay set until a one on `clr_ovr` or `clr_udr` respectively. A new event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| stretch_en | input | 1 | 1 = hold SCL instead of losing or repeating data |
| sw_wr | input | 1 | Software write strobe to the transmit holding register |
| sw_wdata | input | 8 | Software write data |
| sw_rd | input | 1 | Software read strobe of the receive holding register |
| sw_rdata | output | 8 | Receive holding register contents |
| bit_strobe | input | 1 | One pulse per bit slot from the pin driver |
| bit_in | input | 1 | Sampled SDA value for receive |
| bit_out | output | 1 | SDA value to send in the current bit slot |
| clr_ovr | input | 1 | Write-one-to-clear for the overrun flag |
| clr_udr | input | 1 | Write-one-to-clear for the underrun flag |
| txe | output | 1 | Transmit holding register empty |
| rxne | output | 1 | Receive holding register not empty |
| btf | output | 1 | Both stages empty (transmit) or full (receive) |
| scl_hold | output | 1 | Request to hold SCL low |
| ovr_flag | output | 1 | Sticky receive overrun |
| udr_flag | output | 1 | Sticky transmit underrun |

## Verification
The checker tests several relations on every cycle. `scl_hold` always trails `btf` by one cycle. `btf` never coexists with an inconsistent empty or full indication. `btf` cannot rise while stretching is disabled. A write or read during `btf` releases it at the next edge. The sticky flags hold until cleared. Only the directed scenarios can show which byte comes out, in which bit order, and when. That covers seamless reload, the repeated byte on underrun, the byte kept and the byte dropped on overrun, and strobes during a hold leaving the bit count undisturbed.

// File: rtl/i2cdp_pkg.sv
package i2cdp_pkg;
  parameter int unsigned BYTE_W_DEF = 8;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;
endpackage

// File: rtl/i2cdp_bitcnt.sv
module i2cdp_bitcnt #(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic at_last
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_n = cnt_q;
    if (step) begin
      cnt_n = at_last ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/i2cdp_tx.sv
module i2cdp_tx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         stretch_en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         strobe,
  input  logic         clr_udr,
  output logic         dr_empty,
  output logic         btf,
  output logic         bit_out,
  output logic         udr
);
  logic [W-1:0] dr_q, dr_n, sr_q, sr_n;
  logic dr_full_q, dr_full_n;
  logic busy_q, busy_n;
  logic btf_q, btf_n;
  logic udr_q, udr_n;
  logic wr_ok, step, last;

  assign wr_ok = en & wr;
  assign step  = en & strobe & busy_q;

  i2cdp_bitcnt #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .at_last(last)
  );

  always_comb begin
    dr_n      = wr_ok ? wdata : dr_q;
    sr_n      = sr_q;
    dr_full_n = dr_full_q;
    busy_n    = busy_q;
    btf_n     = btf_q;
    udr_n     = clr_udr ? 1'b0 : udr_q;
    if (step) begin
      sr_n = {sr_q[W-2:0], 1'b0};
      if (last) begin
        if (dr_full_q) begin
          sr_n      = dr_q;
          dr_full_n = wr_ok;
        end else if (wr_ok) begin
          sr_n = wdata;
        end else if (stretch_en) begin
          busy_n = 1'b0;
          btf_n  = 1'b1;
        end else begin
          sr_n  = dr_q;
          udr_n = 1'b1;
        end
      end else if (wr_ok) begin
        dr_full_n = 1'b1;
      end
    end else if (en && !busy_q && dr_full_q) begin
      sr_n      = dr_q;
      busy_n    = 1'b1;
      dr_full_n = wr_ok;
      btf_n     = 1'b0;
    end else if (wr_ok) begin
      dr_full_n = 1'b1;
      btf_n     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q      <= '0;
      sr_q      <= '0;
      dr_full_q <= 1'b0;
      busy_q    <= 1'b0;
      btf_q     <= 1'b0;
      udr_q     <= 1'b0;
    end else begin
      dr_q      <= dr_n;
      sr_q      <= sr_n;
      dr_full_q <= dr_full_n;
      busy_q    <= busy_n;
      btf_q     <= btf_n;
      udr_q     <= udr_n;
    end
  end

  assign dr_empty = ~dr_full_q;
  assign btf      = btf_q;
  assign bit_out  = sr_q[W-1];
  assign udr      = udr_q;
endmodule

// File: rtl/i2cdp_rx.sv
module i2cdp_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         stretch_en,
  input  logic         rd,
  input  logic         strobe,
  input  logic         bit_in,
  input  logic         clr_ovr,
  output logic         dr_full,
  output logic [W-1:0] rdata,
  output logic         btf,
  output logic         ovr
);
  logic [W-1:0] dr_q, dr_n, shf_q, shf_n, byte_in;
  logic dr_full_q, dr_full_n;
  logic sr_full_q, sr_full_n;
  logic btf_q, btf_n;
  logic ovr_q, ovr_n;
  logic rd_ok, step, last;

  assign rd_ok   = en & rd & dr_full_q;
  assign step    = en & strobe & ~btf_q;
  assign byte_in = {shf_q[W-2:0], bit_in};

  i2cdp_bitcnt #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .at_last(last)
  );

  always_comb begin
    dr_n      = dr_q;
    shf_n     = shf_q;
    dr_full_n = dr_full_q;
    sr_full_n = sr_full_q;
    btf_n     = btf_q;
    ovr_n     = clr_ovr ? 1'b0 : ovr_q;
    if (rd_ok) begin
      if (sr_full_q) begin
        dr_n      = shf_q;
        sr_full_n = 1'b0;
        btf_n     = 1'b0;
      end else begin
        dr_full_n = 1'b0;
      end
    end
    if (step) begin
      if (!sr_full_q) begin
        shf_n = byte_in;
        if (last) begin
          if (!dr_full_q || rd_ok) begin
            dr_n      = byte_in;
            dr_full_n = 1'b1;
          end else begin
            sr_full_n = 1'b1;
            btf_n     = stretch_en;
          end
        end
      end else if (last) begin
        ovr_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q      <= '0;
      shf_q     <= '0;
      dr_full_q <= 1'b0;
      sr_full_q <= 1'b0;
      btf_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      dr_q      <= dr_n;
      shf_q     <= shf_n;
      dr_full_q <= dr_full_n;
      sr_full_q <= sr_full_n;
      btf_q     <= btf_n;
      ovr_q     <= ovr_n;
    end
  end

  assign dr_full = dr_full_q;
  assign rdata   = dr_q;
  assign btf     = btf_q;
  assign ovr     = ovr_q;
endmodule

// File: rtl/i2c_dbuf_path.sv
module i2c_dbuf_path
  import i2cdp_pkg::*;
#(
  parameter int unsigned W = BYTE_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_mode,
  input  logic         stretch_en,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_wdata,
  input  logic         sw_rd,
  output logic [W-1:0] sw_rdata,
  input  logic         bit_strobe,
  input  logic         bit_in,
  output logic         bit_out,
  input  logic         clr_ovr,
  input  logic         clr_udr,
  output logic         txe,
  output logic         rxne,
  output logic         btf,
  output logic         scl_hold,
  output logic         ovr_flag,
  output logic         udr_flag
);
  dir_e dir;
  logic tx_en, rx_en;
  logic tx_empty, tx_btf, rx_full, rx_btf;
  logic hold_q, hold_n;

  assign dir   = dir_e'(tx_mode);
  assign tx_en = (dir == DIR_TX);
  assign rx_en = (dir == DIR_RX);

  i2cdp_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .stretch_en(stretch_en),
    .wr(sw_wr), .wdata(sw_wdata), .strobe(bit_strobe), .clr_udr(clr_udr),
    .dr_empty(tx_empty), .btf(tx_btf), .bit_out(bit_out), .udr(udr_flag)
  );

  i2cdp_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .stretch_en(stretch_en),
    .rd(sw_rd), .strobe(bit_strobe), .bit_in(bit_in), .clr_ovr(clr_ovr),
    .dr_full(rx_full), .rdata(sw_rdata), .btf(rx_btf), .ovr(ovr_flag)
  );

  assign txe  = tx_en & tx_empty;
  assign rxne = rx_en & rx_full;
  assign btf  = tx_en ? tx_btf : rx_btf;

  always_comb hold_n = btf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_n;
  end

  assign scl_hold = hold_q;
endmodule

// File: rtl/i2cdp_chk.sv
module i2cdp_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_mode,
  input logic stretch_en,
  input logic sw_wr,
  input logic sw_rd,
  input logic clr_ovr,
  input logic clr_udr,
  input logic txe,
  input logic rxne,
  input logic btf,
  input logic scl_hold,
  input logic ovr_flag,
  input logic udr_flag
);
  // R4
  hold_trails_btf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold == $past(btf));

  // R4
  tx_btf_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (btf && tx_mode) |-> txe);

  // R8
  rx_btf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (btf && !tx_mode) |-> rxne);

  // R5
  tx_wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && btf && sw_wr) |=> (!tx_mode || (!btf && !txe)));

  // R9
  rx_rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode && btf && sw_rd) |=> (tx_mode || (rxne && !btf)));

  // R6
  no_stretch_no_btf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stretch_en && !btf) |=> (!btf || (tx_mode != $past(tx_mode))));

  // R11
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_ovr) |=> ovr_flag);

  // R11
  udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_flag && !clr_udr) |=> udr_flag);
endmodule

bind i2c_dbuf_path i2cdp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .stretch_en(stretch_en),
  .sw_wr(sw_wr), .sw_rd(sw_rd), .clr_ovr(clr_ovr), .clr_udr(clr_udr),
  .txe(txe), .rxne(rxne), .btf(btf), .scl_hold(scl_hold),
  .ovr_flag(ovr_flag), .udr_flag(udr_flag)
);

// File: tb/test_i2c_dbuf_path.sv
module test_i2c_dbuf_path;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_mode = 1'b1, stretch_en = 1'b1;
  logic       sw_wr = 1'b0, sw_rd = 1'b0;
  logic [7:0] sw_wdata = '0;
  logic [7:0] sw_rdata;
  logic       bit_strobe = 1'b0, bit_in = 1'b0, bit_out;
  logic       clr_ovr = 1'b0, clr_udr = 1'b0;
  logic       txe, rxne, btf, scl_hold, ovr_flag, udr_flag;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_dbuf_path i_i2c_dbuf_path (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .stretch_en(stretch_en),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rd(sw_rd), .sw_rdata(sw_rdata),
    .bit_strobe(bit_strobe), .bit_in(bit_in), .bit_out(bit_out),
    .clr_ovr(clr_ovr), .clr_udr(clr_udr), .txe(txe), .rxne(rxne),
    .btf(btf), .scl_hold(scl_hold), .ovr_flag(ovr_flag), .udr_flag(udr_flag)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic txm, input logic st);
    @(negedge clk);
    rst_n = 1'b0; tx_mode = txm; stretch_en = st;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_strobe(input logic b);
    bit_strobe = 1'b1; bit_in = b;
    @(negedge clk);
    bit_strobe = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    sw_wr = 1'b1; sw_wdata = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic do_read();
    sw_rd = 1'b1;
    @(negedge clk);
    sw_rd = 1'b0;
  endtask

  task automatic send_byte(input string req, input logic [7:0] exp);
    for (int i = 7; i >= 0; i--) begin
      check(req, "bit_out", {7'b0, bit_out}, {7'b0, exp[i]});
      pulse_strobe(1'b0);
    end
  endtask

  task automatic recv_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) pulse_strobe(d[i]);
  endtask

  task automatic t_tx_stretch();
    do_reset(1'b1, 1'b1);
    check("R1", "txe", {7'b0, txe}, 8'h01);
    check("R1", "btf", {7'b0, btf}, 8'h00);
    check("R1", "scl_hold", {7'b0, scl_hold}, 8'h00);
    check("R1", "rxne/ovr/udr", {5'b0, rxne, ovr_flag, udr_flag}, 8'h00);
    do_write(8'hA5);
    check("R2", "txe after write", {7'b0, txe}, 8'h00);
    @(negedge clk);
    check("R2", "txe after load", {7'b0, txe}, 8'h01);
    do_write(8'h3C);
    check("R2", "txe second write", {7'b0, txe}, 8'h00);
    send_byte("R2", 8'hA5);
    check("R3", "txe after reload", {7'b0, txe}, 8'h01);
    check("R3", "btf after reload", {7'b0, btf}, 8'h00);
    send_byte("R3", 8'h3C);
    check("R4", "btf at empty end", {7'b0, btf}, 8'h01);
    check("R4", "hold same cycle", {7'b0, scl_hold}, 8'h00);
    @(negedge clk);
    check("R4", "hold next cycle", {7'b0, scl_hold}, 8'h01);
    repeat (3) pulse_strobe(1'b0);
    check("R4", "btf after ignored strobes", {7'b0, btf}, 8'h01);
    do_write(8'h96);
    check("R5", "btf on write", {7'b0, btf}, 8'h00);
    check("R5", "txe on write", {7'b0, txe}, 8'h00);
    check("R5", "hold still set", {7'b0, scl_hold}, 8'h01);
    @(negedge clk);
    check("R5", "hold released", {7'b0, scl_hold}, 8'h00);
    check("R5", "txe after load", {7'b0, txe}, 8'h01);
    send_byte("R5", 8'h96);
    check("R4", "btf again", {7'b0, btf}, 8'h01);
  endtask

  task automatic t_tx_underrun();
    do_reset(1'b1, 1'b0);
    do_write(8'h5A);
    @(negedge clk);
    send_byte("R6", 8'h5A);
    check("R6", "udr set", {7'b0, udr_flag}, 8'h01);
    check("R6", "btf stays 0", {7'b0, btf}, 8'h00);
    check("R6", "txe", {7'b0, txe}, 8'h01);
    @(negedge clk);
    check("R6", "no hold", {7'b0, scl_hold}, 8'h00);
    send_byte("R6", 8'h5A);
    repeat (3) @(negedge clk);
    check("R11", "udr sticky", {7'b0, udr_flag}, 8'h01);
    clr_udr = 1'b1;
    @(negedge clk);
    clr_udr = 1'b0;
    check("R11", "udr cleared", {7'b0, udr_flag}, 8'h00);
    repeat (2) @(negedge clk);
    check("R11", "udr stays clear", {7'b0, udr_flag}, 8'h00);
  endtask

  task automatic t_rx_stretch();
    do_reset(1'b0, 1'b1);
    check("R1", "rxne", {7'b0, rxne}, 8'h00);
    recv_byte(8'hC3);
    check("R7", "rxne", {7'b0, rxne}, 8'h01);
    check("R7", "rdata", sw_rdata, 8'hC3);
    check("R7", "btf", {7'b0, btf}, 8'h00);
    recv_byte(8'h1E);
    check("R8", "btf", {7'b0, btf}, 8'h01);
    check("R8", "rdata kept", sw_rdata, 8'hC3);
    @(negedge clk);
    check("R8", "hold", {7'b0, scl_hold}, 8'h01);
    repeat (4) pulse_strobe(1'b1);
    check("R8", "rdata after ignored strobes", sw_rdata, 8'hC3);
    do_read();
    check("R9", "rdata moved", sw_rdata, 8'h1E);
    check("R9", "rxne kept", {7'b0, rxne}, 8'h01);
    check("R9", "btf cleared", {7'b0, btf}, 8'h00);
    @(negedge clk);
    check("R9", "hold released", {7'b0, scl_hold}, 8'h00);
    do_read();
    check("R9", "rxne cleared", {7'b0, rxne}, 8'h00);
    recv_byte(8'h77);
    check("R8", "count intact", sw_rdata, 8'h77);
    check("R7", "rxne", {7'b0, rxne}, 8'h01);
  endtask

  task automatic t_rx_overrun();
    do_reset(1'b0, 1'b0);
    recv_byte(8'h81);
    recv_byte(8'h42);
    check("R10", "no btf", {7'b0, btf}, 8'h00);
    check("R10", "ovr not yet", {7'b0, ovr_flag}, 8'h00);
    recv_byte(8'hFF);
    check("R10", "ovr set", {7'b0, ovr_flag}, 8'h01);
    check("R10", "first kept", sw_rdata, 8'h81);
    check("R10", "no hold", {7'b0, scl_hold}, 8'h00);
    do_read();
    check("R10", "second kept", sw_rdata, 8'h42);
    check("R10", "rxne", {7'b0, rxne}, 8'h01);
    do_read();
    check("R10", "rxne clear", {7'b0, rxne}, 8'h00);
    check("R10", "third dropped", sw_rdata, 8'h42);
    check("R11", "ovr sticky", {7'b0, ovr_flag}, 8'h01);
    clr_ovr = 1'b1;
    @(negedge clk);
    clr_ovr = 1'b0;
    check("R11", "ovr cleared", {7'b0, ovr_flag}, 8'h00);
  endtask

  initial begin
    t_tx_stretch();
    t_tx_underrun();
    t_rx_stretch();
    t_rx_overrun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule